// File: doc/BRIEF.md
# Round-Robin Shared Bus Arbiter with Address Decode

This block sits between up to eight processor caches and every target on a single shared system bus. Each cache raises a request carrying an address, a direction and write data. The arbiter picks one requester at a time in rotating order and decodes the physical address to one of five outcomes: a direct window onto cache storage at the bottom of the map, an on-chip boot ROM, a memory-mapped I/O region, the external DRAM controller's request FIFOs, or an error for unmapped space. It then issues the transaction and holds the grant until the target signals completion.

Only one transaction is in flight at any time, and a read blocks its requester until data comes back. All caches therefore observe one global order of memory operations. Every write that goes to DRAM is broadcast to all caches on a snoop channel in the same cycle it enters the DRAM write FIFO, so stale copies can be invalidated in grant order. The cache window needs no DRAM, so boot code can use it as working memory before DRAM calibration completes.

Top module: `shared_bus_arb`

## Requirements
- R1: At most one grant bit is high at a time. After requester i is served, the search for the next grant starts at (i+1) mod N among the eligible requesters. The search pointer starts at 0.
- R2: A grant is held until its transaction completes. Completion is signalled by a one-cycle pulse on the requester's `done` bit, and the grant drops in that same cycle.
- R3: Each granted transaction that reaches a bus target produces exactly one one-cycle strobe: `dram_rd_push`, `dram_wr_push`, `io_req` or `win_req`. A DRAM read completes only after `dram_rd_valid` returns.
- R4: The address map is fixed as follows. Addresses below 8192 go to the cache window. Addresses with (a & 0xFFFFFC00) == 0x1FC00000 go to the boot ROM. Addresses with (a & 0xFFFF0000) == 0x20000000 go to I/O. Addresses at or above 0x80000000 go to DRAM. Everything else is unmapped.
- R5: A read returns its target's data on `rdata` in the `done` cycle, and a write returns `rdata` = 0. Boot ROM word k (address bits [9:2]) holds 0xB0070000 | ((37*k+11) mod 65536).
- R6: A DRAM write produces one `dram_wr_push` carrying `bus_addr` and `bus_wdata`. In the same cycle, `snoop_valid` is high with `snoop_addr` equal to the write address and `snoop_src` equal to the requester index.
- R7: A request to unmapped space, or a write to the boot ROM, completes with `err` = 1 and `rdata` = 0. No target strobe is issued for it.
- R8: While `dram_wr_full` is high, DRAM writes are not granted. Requests to other targets are still served.
- R9: After reset, `grant`, `done`, `err` and every strobe and snoop output are 0.
- R10: For a ROM read, a DRAM write or an error request presented to an idle bus, `done` rises on the third rising edge after the request is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Request per requester, held until its done pulse |
| req_write | input | N | 1 = write, 0 = read, per requester |
| req_addr | input | N*AW | Byte address per requester, packed |
| req_wdata | input | N*DW | Write data per requester, packed |
| grant | output | N | One-hot grant, held for the whole transaction |
| done | output | N | One-cycle completion pulse to the served requester |
| rdata | output | DW | Read data, valid with done |
| err | output | 1 | Bus error flag, valid with done |
| bus_addr | output | AW | Shared target address |
| bus_wdata | output | DW | Shared target write data |
| bus_we | output | 1 | Shared target direction |
| dram_wr_push | output | 1 | Push into DRAM write FIFO |
| dram_wr_full | input | 1 | DRAM write FIFO full |
| dram_rd_push | output | 1 | Push into DRAM read request FIFO |
| dram_rd_valid | input | 1 | DRAM read data valid |
| dram_rd_data | input | DW | DRAM read data |
| io_req | output | 1 | I/O access strobe |
| io_ack | input | 1 | I/O access complete |
| io_rdata | input | DW | I/O read data |
| win_req | output | 1 | Cache window access strobe |
| win_ack | input | 1 | Cache window access complete |
| win_rdata | input | DW | Cache window read data |
| snoop_valid | output | 1 | Write broadcast to all caches |
| snoop_addr | output | AW | Broadcast write address |
| snoop_src | output | log2(N) | Index of the writing requester |

## Verification
The grant registers on the first edge that samples a request. The target strobe and snoop follow one edge later. `done` arrives one edge after the completion condition, which makes it the third edge for ROM reads, DRAM writes and error requests; I/O, window and DRAM reads add their responder's latency. Inputs are driven and outputs sampled on the falling edge, so every check sees settled register values. Requests are dropped on the same falling edge where their `done` is seen, before the next arbitration edge. The bench predicts the serving order, data, error and strobe counts from the address map and the rotating pointer. The R10 latency is checked by counting falling edges from a single request on an idle bus.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [2:0] {T_WIN, T_ROM, T_IO, T_DRAM, T_NONE} tgt_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
endpackage

// File: rtl/sba_addr_decode.sv
module sba_addr_decode
  import sba_pkg::*;
#(
  parameter int AW = 32,
  parameter int WIN_BYTES = 8192,
  parameter logic [AW-1:0] ROM_BASE = 32'h1FC0_0000,
  parameter logic [AW-1:0] ROM_MASK = 32'hFFFF_FC00,
  parameter logic [AW-1:0] IO_BASE = 32'h2000_0000,
  parameter logic [AW-1:0] IO_MASK = 32'hFFFF_0000,
  parameter logic [AW-1:0] DRAM_BASE = 32'h8000_0000
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt
);
  always_comb begin
    if (addr < AW'(WIN_BYTES))                tgt = T_WIN;
    else if ((addr & ROM_MASK) == ROM_BASE)   tgt = T_ROM;
    else if ((addr & IO_MASK) == IO_BASE)     tgt = T_IO;
    else if (addr >= DRAM_BASE)               tgt = T_DRAM;
    else                                      tgt = T_NONE;
  end
endmodule

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] ptr,
  output logic          hit,
  output logic [IW-1:0] win
);
  int j;
  always_comb begin
    hit = 1'b0;
    win = '0;
    j = 0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr) + k) % N;
      if (!hit && elig[j]) begin
        hit = 1'b1;
        win = IW'(j);
      end
    end
  end
endmodule

// File: rtl/sba_boot_rom.sv
module sba_boot_rom #(
  parameter int WORDS = 256,
  parameter int DW = 32,
  localparam int RAW = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           en,
  input  logic [RAW-1:0] addr,
  output logic [DW-1:0]  q
);
  logic [DW-1:0] mem [WORDS];

  initial begin
    for (int k = 0; k < WORDS; k++)
      mem[k] = DW'(32'hB007_0000 | ((37 * k + 11) % 65536));
  end

  always_ff @(posedge clk) begin
    if (en) q <= mem[addr];
  end
endmodule

// File: rtl/shared_bus_arb.sv
module shared_bus_arb
  import sba_pkg::*;
#(
  parameter int N = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WIN_BYTES = 8192,
  parameter int ROM_WORDS = 256,
  parameter logic [AW-1:0] ROM_BASE = 32'h1FC0_0000,
  parameter logic [AW-1:0] ROM_MASK = 32'hFFFF_FC00,
  parameter logic [AW-1:0] IO_BASE = 32'h2000_0000,
  parameter logic [AW-1:0] IO_MASK = 32'hFFFF_0000,
  parameter logic [AW-1:0] DRAM_BASE = 32'h8000_0000,
  localparam int IW = $clog2(N),
  localparam int RAW = $clog2(ROM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_valid,
  input  logic [N-1:0]    req_write,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_wdata,
  output logic [N-1:0]    grant,
  output logic [N-1:0]    done,
  output logic [DW-1:0]   rdata,
  output logic            err,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_we,
  output logic            dram_wr_push,
  input  logic            dram_wr_full,
  output logic            dram_rd_push,
  input  logic            dram_rd_valid,
  input  logic [DW-1:0]   dram_rd_data,
  output logic            io_req,
  input  logic            io_ack,
  input  logic [DW-1:0]   io_rdata,
  output logic            win_req,
  input  logic            win_ack,
  input  logic [DW-1:0]   win_rdata,
  output logic            snoop_valid,
  output logic [AW-1:0]   snoop_addr,
  output logic [IW-1:0]   snoop_src
);

  // per-requester decode and eligibility
  tgt_e        rq_tgt [N];
  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_req
    sba_addr_decode #(
      .AW(AW), .WIN_BYTES(WIN_BYTES),
      .ROM_BASE(ROM_BASE), .ROM_MASK(ROM_MASK),
      .IO_BASE(IO_BASE), .IO_MASK(IO_MASK), .DRAM_BASE(DRAM_BASE)
    ) u_dec (
      .addr(req_addr[g*AW +: AW]),
      .tgt (rq_tgt[g])
    );
    // a DRAM write may not win while the write FIFO is full
    assign elig[g] = req_valid[g] &
                     ~(dram_wr_full & req_write[g] & (rq_tgt[g] == T_DRAM));
  end

  st_e           state;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] cur_idx;
  tgt_e          cur_tgt;
  logic          cur_wr;
  logic          cur_bad;

  logic          pick_hit;
  logic [IW-1:0] pick_idx;

  sba_rr_pick #(.N(N)) u_rr (
    .elig(elig),
    .ptr (ptr_q),
    .hit (pick_hit),
    .win (pick_idx)
  );

  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  tgt_e          sel_tgt;
  logic          sel_wr;
  assign sel_addr  = req_addr[pick_idx*AW +: AW];
  assign sel_wdata = req_wdata[pick_idx*DW +: DW];
  assign sel_tgt   = rq_tgt[pick_idx];
  assign sel_wr    = req_write[pick_idx];

  // boot ROM, read during the issue cycle
  logic [DW-1:0] rom_q;
  logic          rom_en;
  assign rom_en = (state == S_ISSUE) && (cur_tgt == T_ROM) && !cur_bad;

  sba_boot_rom #(.WORDS(ROM_WORDS), .DW(DW)) u_rom (
    .clk (clk),
    .en  (rom_en),
    .addr(bus_addr[RAW+1:2]),
    .q   (rom_q)
  );

  // completion condition while waiting
  logic          fin;
  logic [DW-1:0] fin_data;
  always_comb begin
    fin = 1'b0;
    fin_data = '0;
    if (cur_bad) begin
      fin = 1'b1;
    end else begin
      case (cur_tgt)
        T_DRAM: begin fin = cur_wr | dram_rd_valid; fin_data = dram_rd_data; end
        T_ROM:  begin fin = 1'b1;    fin_data = rom_q;     end
        T_IO:   begin fin = io_ack;  fin_data = io_rdata;  end
        T_WIN:  begin fin = win_ack; fin_data = win_rdata; end
        default: fin = 1'b1;
      endcase
    end
  end

  logic [IW-1:0] ptr_next;
  assign ptr_next = (cur_idx == IW'(N-1)) ? '0 : cur_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      ptr_q        <= '0;
      cur_idx      <= '0;
      cur_tgt      <= T_NONE;
      cur_wr       <= 1'b0;
      cur_bad      <= 1'b0;
      grant        <= '0;
      done         <= '0;
      rdata        <= '0;
      err          <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      bus_we       <= 1'b0;
      dram_wr_push <= 1'b0;
      dram_rd_push <= 1'b0;
      io_req       <= 1'b0;
      win_req      <= 1'b0;
      snoop_valid  <= 1'b0;
      snoop_addr   <= '0;
      snoop_src    <= '0;
    end else begin
      done         <= '0;
      err          <= 1'b0;
      dram_wr_push <= 1'b0;
      dram_rd_push <= 1'b0;
      io_req       <= 1'b0;
      win_req      <= 1'b0;
      snoop_valid  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (pick_hit) begin
            grant     <= {{(N-1){1'b0}}, 1'b1} << pick_idx;
            cur_idx   <= pick_idx;
            cur_tgt   <= sel_tgt;
            cur_wr    <= sel_wr;
            cur_bad   <= (sel_tgt == T_NONE) || (sel_tgt == T_ROM && sel_wr);
            bus_addr  <= sel_addr;
            bus_wdata <= sel_wdata;
            bus_we    <= sel_wr;
            state     <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (!cur_bad) begin
            case (cur_tgt)
              T_DRAM: begin
                if (cur_wr) begin
                  dram_wr_push <= 1'b1;
                  snoop_valid  <= 1'b1;
                  snoop_addr   <= bus_addr;
                  snoop_src    <= cur_idx;
                end else begin
                  dram_rd_push <= 1'b1;
                end
              end
              T_IO:    io_req  <= 1'b1;
              T_WIN:   win_req <= 1'b1;
              default: ;
            endcase
          end
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (fin) begin
            done  <= grant;
            grant <= '0;
            rdata <= (cur_wr || cur_bad) ? '0 : fin_data;
            err   <= cur_bad;
            ptr_q <= ptr_next;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
  parameter int N = 8,
  parameter int AW = 32,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  grant,
  input logic [N-1:0]  done,
  input logic          err,
  input logic          dram_wr_push,
  input logic          dram_wr_full,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          snoop_valid,
  input logic [AW-1:0] snoop_addr,
  input logic [IW-1:0] snoop_src
);
  // R1
  a_r1_onehot_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |=> (grant == $past(grant)) || (grant == '0 && done == $past(grant)));

  // R2
  a_r2_done_from_grant: assert property (@(posedge clk) disable iff (rst)
    (done != '0) |-> (done == $past(grant)));

  // R7
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err |-> $onehot(done));

  // R6
  a_r6_snoop: assert property (@(posedge clk) disable iff (rst)
    snoop_valid |-> (dram_wr_push && bus_we && snoop_addr == bus_addr && grant[snoop_src]));

  // R8
  a_r8_full: assert property (@(posedge clk) disable iff (rst)
    dram_wr_push |-> !$past(dram_wr_full, 2));
endmodule

bind shared_bus_arb sba_checker #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .grant(grant), .done(done), .err(err),
  .dram_wr_push(dram_wr_push), .dram_wr_full(dram_wr_full),
  .bus_we(bus_we), .bus_addr(bus_addr),
  .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_src(snoop_src)
);

// File: tb/tb_shared_bus_arb.sv
`timescale 1ns/1ps
module tb_shared_bus_arb;
  localparam int N = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [N-1:0]    req_valid, req_write;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic [N-1:0]    grant, done;
  logic [DW-1:0]   rdata;
  logic            err;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata;
  logic            bus_we;
  logic            dram_wr_push, dram_rd_push, io_req, win_req;
  logic            dram_wr_full = 1'b0;
  logic            dram_rd_valid, io_ack, win_ack;
  logic [DW-1:0]   dram_rd_data, io_rdata, win_rdata;
  logic            snoop_valid;
  logic [AW-1:0]   snoop_addr;
  logic [2:0]      snoop_src;

  logic [N-1:0] pend = '0;
  logic [31:0]  baddr [N];
  logic         bwr [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_addr[i*AW +: AW]  = baddr[i];
      req_wdata[i*DW +: DW] = baddr[i] ^ 32'h5A5A_0000 ^ i;
      req_write[i]          = bwr[i];
    end
    req_valid = pend;
  end

  shared_bus_arb dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant), .done(done),
    .rdata(rdata), .err(err), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .dram_wr_push(dram_wr_push), .dram_wr_full(dram_wr_full),
    .dram_rd_push(dram_rd_push), .dram_rd_valid(dram_rd_valid),
    .dram_rd_data(dram_rd_data), .io_req(io_req), .io_ack(io_ack),
    .io_rdata(io_rdata), .win_req(win_req), .win_ack(win_ack),
    .win_rdata(win_rdata), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .snoop_src(snoop_src)
  );

  // target responders
  logic [2:0]  rd_cnt;
  logic [31:0] rd_a;
  always @(posedge clk) begin
    if (rst) begin
      rd_cnt <= 0; rd_a <= 0;
      dram_rd_valid <= 0; dram_rd_data <= 0;
      io_ack <= 0; io_rdata <= 0; win_ack <= 0; win_rdata <= 0;
    end else begin
      dram_rd_valid <= 1'b0;
      io_ack  <= io_req;
      win_ack <= win_req;
      if (io_req)  io_rdata  <= bus_addr ^ 32'h1010_1010;
      if (win_req) win_rdata <= ~bus_addr;
      if (dram_rd_push) begin
        rd_cnt <= 3; rd_a <= bus_addr;
      end else if (rd_cnt != 0) begin
        rd_cnt <= rd_cnt - 1;
        if (rd_cnt == 1) begin
          dram_rd_valid <= 1'b1;
          dram_rd_data  <= rd_a ^ 32'hD00D_0000;
        end
      end
    end
  end

  int total = 0;
  int bad = 0;
  int ptr = 0;
  int done_cyc [N];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // region per R4: 0 window, 1 rom, 2 io, 3 dram, 4 unmapped
  function automatic int region(input logic [31:0] a);
    if (a < 32'd8192) return 0;
    if ((a & 32'hFFFF_FC00) == 32'h1FC0_0000) return 1;
    if ((a & 32'hFFFF_0000) == 32'h2000_0000) return 2;
    if (a >= 32'h8000_0000) return 3;
    return 4;
  endfunction

  function automatic bit exp_err(input logic [31:0] a, input bit w);
    return (region(a) == 4) || (region(a) == 1 && w);
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [31:0] a, input bit w);
    if (w || exp_err(a, w)) return 32'h0;
    case (region(a))
      0: return ~a;
      1: return 32'hB007_0000 | ((37 * ((a >> 2) & 32'hFF) + 11) % 65536);
      2: return a ^ 32'h1010_1010;
      default: return a ^ 32'hD00D_0000;
    endcase
  endfunction

  function automatic logic [31:0] rand_addr();
    int r;
    r = $urandom % 5;
    case (r)
      0: return ($urandom % 8192) & ~32'h3;
      1: return 32'h1FC0_0000 + 4 * ($urandom % 256);
      2: return 32'h2000_0000 | (($urandom % 65536) & ~32'h3);
      3: return 32'h8000_0000 | ($urandom & ~32'h3);
      default: return 32'h4000_0000 | ($urandom & 32'h0FFF_FFFC);
    endcase
  endfunction

  // run pending requests until all are served
  task automatic run_batch(input int hold, input bit chk_order);
    int cyc = 0;
    int n_snoop = 0, exp_snoop = 0, n_stb = 0, exp_stb = 0;
    for (int i = 0; i < N; i++) begin
      done_cyc[i] = -1;
      if (pend[i]) begin
        if (region(baddr[i]) == 3 && bwr[i]) exp_snoop++;
        if (!exp_err(baddr[i], bwr[i]) && region(baddr[i]) != 1) exp_stb++;
      end
    end
    while (pend != '0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (cyc >= hold) dram_wr_full = 1'b0;
      if (dram_wr_push || dram_rd_push || io_req || win_req) n_stb++;
      if (snoop_valid) begin
        n_snoop++;
        chk(pend[snoop_src] && bwr[snoop_src] && region(baddr[snoop_src]) == 3,
            "R6 snoop src", {29'd0, snoop_src}, 32'h0);
        chk(snoop_addr == baddr[snoop_src], "R6 snoop addr", snoop_addr, baddr[snoop_src]);
        chk(bus_wdata == (baddr[snoop_src] ^ 32'h5A5A_0000 ^ 32'(snoop_src)),
            "R6 wdata", bus_wdata, baddr[snoop_src] ^ 32'h5A5A_0000 ^ 32'(snoop_src));
      end
      if (done != '0) begin
        int idx = 0;
        chk($onehot(done), "R2 done onehot", {24'd0, done}, 32'h1);
        for (int i = 0; i < N; i++) if (done[i]) idx = i;
        if (chk_order) begin
          int e = -1;
          for (int k = 0; k < N; k++) begin
            if (e < 0 && pend[(ptr + k) % N]) e = (ptr + k) % N;
          end
          chk(idx == e, "R1 order", idx, e);
        end
        chk(rdata == exp_rdata(baddr[idx], bwr[idx]), "R5 rdata", rdata,
            exp_rdata(baddr[idx], bwr[idx]));
        chk(err == exp_err(baddr[idx], bwr[idx]), "R7 err", {31'd0, err},
            {31'd0, exp_err(baddr[idx], bwr[idx])});
        chk(grant == '0, "R2 grant drops with done", {24'd0, grant}, 32'h0);
        done_cyc[idx] = cyc;
        pend[idx] = 1'b0;
        ptr = (idx + 1) % N;
      end
    end
    chk(pend == '0, "R2 batch completes", {24'd0, pend}, 32'h0);
    pend = '0;
    chk(n_snoop == exp_snoop, "R6 snoop count", n_snoop, exp_snoop);
    chk(n_stb == exp_stb, "R3 strobe count", n_stb, exp_stb);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin baddr[i] = 0; bwr[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(grant == '0 && done == '0 && !err, "R9 reset outputs", {grant, done, 15'd0, err}, 32'h0);
    chk(!dram_wr_push && !dram_rd_push && !io_req && !win_req && !snoop_valid,
        "R9 reset strobes", {27'd0, dram_wr_push, dram_rd_push, io_req, win_req, snoop_valid}, 32'h0);

    // R10 latency: single ROM read on idle bus
    baddr[3] = 32'h1FC0_0010; bwr[3] = 0; pend = 8'h08;
    @(negedge clk); chk(grant == 8'h08, "R10 grant after 1 edge", {24'd0, grant}, 32'h08);
    @(negedge clk); chk(done == '0, "R10 no early done", {24'd0, done}, 32'h0);
    @(negedge clk);
    chk(done == 8'h08, "R10 done on 3rd edge", {24'd0, done}, 32'h08);
    chk(rdata == exp_rdata(32'h1FC0_0010, 0), "R5 rom word 4", rdata, exp_rdata(32'h1FC0_0010, 0));
    pend = '0; ptr = 4;
    @(negedge clk);

    // R7 directed: unmapped read and ROM write
    baddr[2] = 32'h4000_1000; bwr[2] = 0;
    baddr[5] = 32'h1FC0_0020; bwr[5] = 1;
    pend = 8'h24;
    run_batch(0, 1);

    // R4 window boundary: 8188 is window, 8192 is unmapped
    baddr[0] = 32'd8188; bwr[0] = 0;
    baddr[1] = 32'd8192; bwr[1] = 0;
    baddr[7] = 32'h8000_0000; bwr[7] = 1;
    pend = 8'h83;
    run_batch(0, 1);
    chk(done_cyc[7] < done_cyc[0] && done_cyc[0] < done_cyc[1], "R1 wrap order",
        done_cyc[7], done_cyc[0]);

    // R8 directed: DRAM write held off while FIFO full
    baddr[0] = 32'h8000_1000; bwr[0] = 1;
    baddr[1] = 32'h1FC0_0004; bwr[1] = 0;
    dram_wr_full = 1'b1;
    pend = 8'h03;
    run_batch(40, 0);
    chk(done_cyc[1] > 0 && done_cyc[1] < 40, "R8 other target served", done_cyc[1], 40);
    chk(done_cyc[0] > 40, "R8 write waits for not-full", done_cyc[0], 40);

    // random batches
    for (int b = 0; b < 80; b++) begin
      logic [N-1:0] m;
      m = N'($urandom % 256);
      if (m == '0) m = 8'h01;
      for (int i = 0; i < N; i++) begin
        baddr[i] = rand_addr();
        bwr[i] = $urandom % 2;
      end
      @(negedge clk);
      pend = m;
      run_batch(0, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule